// File: doc/BRIEF.md
# PoE Port Current Supervisor

This block supervises one powered Ethernet supply port. It receives a sampled current code for the port, a 1 ms timebase tick, a host enable, an active-low global kill input and a supply power-good input. From these it drives the port switch enable and reports a two-bit status. The status shows whether the port is off, powered, shut down for overload or shut down for no load.

While the port is powered, two filter timers qualify faults. One counts ticks while the current stays above the overload threshold. The other counts ticks while the current stays below the no-load threshold. Only a sustained excursion past the programmed tick count switches the port off, and each shutdown cause has its own retry delay, after which the port is powered again. The kill input and a failing supply remove power at once. Thresholds and timer limits load from a configuration strobe, which takes effect only while the port is off.

Top module: `poePortSupervisor`

## Requirements
- R1: After reset the port is off: `portOn` is 0 and `status` is 0. The status encoding is 0 = off, 1 = on, 2 = overload shutdown, 3 = no-load shutdown.
- R2: The port goes from off to on at the next clock edge when `hostEn`, `killN` and `pwrGood` are all 1.
- R3: The port is in overload when `curCode` is strictly greater than the overload threshold. A current equal to the threshold does not count. A powered port that is in overload on `cfgOvlTime`+1 consecutive ticks shuts down at the edge of the last of those ticks: `status` becomes 2 and `portOn` becomes 0.
- R4: The port is under-loaded when `curCode` is strictly less than the no-load threshold. A current equal to the threshold does not count. A powered port that is under-loaded on `cfgUdlTime`+1 consecutive ticks shuts down at the edge of the last of those ticks with `status` 3. At any time, at most one of the two filter timers holds a count.
- R5: A tick on which the current lies inside both limits clears the fault count. After that, a new excursion needs the full number of ticks before it can trip.
- R6: After an overload shutdown, the port powers up again (`status` 1) at the edge of the `cfgOvlRec`+1-th tick after the shutdown.
- R7: After a no-load shutdown, the port powers up again at the edge of the `cfgUdlRec`+1-th tick after the shutdown.
- R8: When `killN` is low, `portOn` is 0 in the same cycle, with no clock edge needed. `status` is 0 from the next edge, and the port stays off while `killN` is low.
- R9: When `pwrGood` is low, `portOn` is 0 in the same cycle and `status` is 0 from the next edge.
- R10: When `hostEn` is low, `status` is 0 from the next edge and any recovery count is discarded. A later shutdown waits the full recovery delay.
- R11: A configuration write (`cfgWe`) is accepted only while `status` is 0. A write in any other state is ignored.
- R12: Filter and recovery counts advance only on cycles where `tick1ms` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick1ms | input | 1 | One-cycle 1 ms timebase pulse |
| curCode | input | CUR_W | Sampled port current code |
| hostEn | input | 1 | Host enable for the port |
| killN | input | 1 | Active-low global kill, unfiltered |
| pwrGood | input | 1 | Supply power good, low on failure |
| cfgWe | input | 1 | Configuration load strobe |
| cfgCutThr | input | CUR_W | Overload threshold |
| cfgMinThr | input | CUR_W | No-load threshold |
| cfgOvlTime | input | TMR_W | Overload filter limit in ticks |
| cfgUdlTime | input | TMR_W | No-load filter limit in ticks |
| cfgOvlRec | input | TMR_W | Overload retry delay in ticks |
| cfgUdlRec | input | TMR_W | No-load retry delay in ticks |
| portOn | output | 1 | Port switch enable |
| status | output | 2 | Port state code |

## Verification
The filter paths are driven with currents exactly at each threshold and one step past it, to separate strict from non-strict comparison. Overload runs that are cut short by one in-range tick show that the count is cleared rather than paused. Cycles with the tick low are mixed into fault and recovery runs, so that counting per tick can be told apart from counting per clock. The kill and supply inputs are sampled before the edge, which separates a combinational power removal from a registered one. A host-disable during recovery, followed by a second shutdown, shows whether the recovery count was discarded or only paused.

// File: rtl/psup_pkg.sv
package psup_pkg;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_ON  = 2'd1,
    ST_OVL = 2'd2,
    ST_UDL = 2'd3
  } portState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic qualEn;    // port powered: fault filters may run
    logic recEn;     // in a shutdown state: recovery timer runs
    logic recIsOvl;  // recovery limit select: overload delay
    logic cfgOpen;   // port off: configuration may load
  } ctlStrobe_t;

  // events from datapath to control
  typedef struct packed {
    logic ovlTrip;
    logic udlTrip;
    logic recDone;
  } dpFlag_t;

endpackage

// File: rtl/psupTickTimer.sv
module psupTickTimer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             tick,
  input  logic [TMR_W-1:0] limit,
  output logic             expire,
  output logic [TMR_W-1:0] cnt
);

  assign expire = run && tick && (cnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (!run)           cnt <= '0;
    else if (tick && !expire) cnt <= cnt + 1'b1;
  end

  // count never passes its limit while running (R5 filter window)
  p_cnt_within_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (cnt <= limit));

  // no tick, no progress (R12)
  p_hold_without_tick_r12: assert property (@(posedge clk) disable iff (!rstN)
    (run && !tick) |=> (!run || $stable(cnt)));

endmodule

// File: rtl/psupDatapath.sv
module psupDatapath
  import psup_pkg::*;
#(
  parameter int CUR_W       = 12,
  parameter int TMR_W       = 16,
  parameter int DEF_CUT     = 680,
  parameter int DEF_MIN     = 7,
  parameter int DEF_OVL_T   = 60,
  parameter int DEF_UDL_T   = 350,
  parameter int DEF_OVL_REC = 5000,
  parameter int DEF_UDL_REC = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick1ms,
  input  logic [CUR_W-1:0] curCode,
  input  logic             cfgWe,
  input  logic [CUR_W-1:0] cfgCutThr,
  input  logic [CUR_W-1:0] cfgMinThr,
  input  logic [TMR_W-1:0] cfgOvlTime,
  input  logic [TMR_W-1:0] cfgUdlTime,
  input  logic [TMR_W-1:0] cfgOvlRec,
  input  logic [TMR_W-1:0] cfgUdlRec,
  input  ctlStrobe_t       ctl,
  output dpFlag_t          flags
);

  logic [CUR_W-1:0] cutThr, minThr;
  logic [TMR_W-1:0] ovlTime, udlTime, ovlRec, udlRec;
  logic             cfgLoad;

  assign cfgLoad = cfgWe && ctl.cfgOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cutThr  <= CUR_W'(DEF_CUT);
      minThr  <= CUR_W'(DEF_MIN);
      ovlTime <= TMR_W'(DEF_OVL_T);
      udlTime <= TMR_W'(DEF_UDL_T);
      ovlRec  <= TMR_W'(DEF_OVL_REC);
      udlRec  <= TMR_W'(DEF_UDL_REC);
    end else if (cfgLoad) begin
      cutThr  <= cfgCutThr;
      minThr  <= cfgMinThr;
      ovlTime <= cfgOvlTime;
      udlTime <= cfgUdlTime;
      ovlRec  <= cfgOvlRec;
      udlRec  <= cfgUdlRec;
    end
  end

  logic overCur, underCur;
  assign overCur  = curCode > cutThr;
  assign underCur = (curCode < minThr) && !overCur;  // overload has priority

  logic             ovlRun, udlRun;
  logic [TMR_W-1:0] ovlCnt, udlCnt, recCnt, recLimit;

  assign ovlRun   = ctl.qualEn && overCur;
  assign udlRun   = ctl.qualEn && underCur;
  assign recLimit = ctl.recIsOvl ? ovlRec : udlRec;

  psupTickTimer #(.TMR_W(TMR_W)) ovlTimer_i (
    .clk(clk), .rstN(rstN), .run(ovlRun), .tick(tick1ms),
    .limit(ovlTime), .expire(flags.ovlTrip), .cnt(ovlCnt));

  psupTickTimer #(.TMR_W(TMR_W)) udlTimer_i (
    .clk(clk), .rstN(rstN), .run(udlRun), .tick(tick1ms),
    .limit(udlTime), .expire(flags.udlTrip), .cnt(udlCnt));

  psupTickTimer #(.TMR_W(TMR_W)) recTimer_i (
    .clk(clk), .rstN(rstN), .run(ctl.recEn), .tick(tick1ms),
    .limit(recLimit), .expire(flags.recDone), .cnt(recCnt));

  // configuration frozen unless the port is off (R11)
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.cfgOpen |=> ($stable(cutThr) && $stable(minThr) && $stable(ovlTime)
                      && $stable(udlTime) && $stable(ovlRec) && $stable(udlRec)));

  // at most one filter holds a count (R4)
  p_one_filter_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ovlCnt != '0, udlCnt != '0}));

  // recovery count empty when the recovery timer is idle (R10)
  p_rec_idle_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.recEn |=> (!ctl.recEn || recCnt == '0));

endmodule

// File: rtl/psupControl.sv
module psupControl
  import psup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostEn,
  input  logic       killN,
  input  logic       pwrGood,
  input  dpFlag_t    flags,
  output ctlStrobe_t ctl,
  output portState_t state,
  output logic       portOn
);

  logic       allowed;
  portState_t stateNxt;

  assign allowed = hostEn && killN && pwrGood;

  always_comb begin
    stateNxt = state;
    if (!allowed) begin
      stateNxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: stateNxt = ST_ON;
        ST_ON: begin
          if (flags.ovlTrip)      stateNxt = ST_OVL;
          else if (flags.udlTrip) stateNxt = ST_UDL;
        end
        ST_OVL: if (flags.recDone) stateNxt = ST_ON;
        ST_UDL: if (flags.recDone) stateNxt = ST_ON;
        default: stateNxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNxt;
  end

  assign ctl.qualEn   = (state == ST_ON);
  assign ctl.recEn    = (state == ST_OVL) || (state == ST_UDL);
  assign ctl.recIsOvl = (state == ST_OVL);
  assign ctl.cfgOpen  = (state == ST_OFF);

  // kill and supply failure bypass the state register
  assign portOn = (state == ST_ON) && killN && pwrGood;

  p_kill_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !killN |=> (state == ST_OFF));

  p_supply_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> (state == ST_OFF));

  p_host_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !hostEn |=> (state == ST_OFF));

  p_ovl_trip_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ON && flags.ovlTrip && allowed) |=> (state == ST_OVL && !portOn));

  p_udl_trip_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ON && !flags.ovlTrip && flags.udlTrip && allowed) |=> (state == ST_UDL));

  p_retry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OVL && flags.recDone && allowed) |=> (state == ST_ON));

  p_retry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UDL && flags.recDone && allowed) |=> (state == ST_ON));

  p_power_up_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && allowed) |=> (state == ST_ON));

endmodule

// File: rtl/poePortSupervisor.sv
module poePortSupervisor
  import psup_pkg::*;
#(
  parameter int CUR_W       = 12,
  parameter int TMR_W       = 16,
  parameter int DEF_CUT     = 680,
  parameter int DEF_MIN     = 7,
  parameter int DEF_OVL_T   = 60,
  parameter int DEF_UDL_T   = 350,
  parameter int DEF_OVL_REC = 5000,
  parameter int DEF_UDL_REC = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick1ms,
  input  logic [CUR_W-1:0] curCode,
  input  logic             hostEn,
  input  logic             killN,
  input  logic             pwrGood,
  input  logic             cfgWe,
  input  logic [CUR_W-1:0] cfgCutThr,
  input  logic [CUR_W-1:0] cfgMinThr,
  input  logic [TMR_W-1:0] cfgOvlTime,
  input  logic [TMR_W-1:0] cfgUdlTime,
  input  logic [TMR_W-1:0] cfgOvlRec,
  input  logic [TMR_W-1:0] cfgUdlRec,
  output logic             portOn,
  output logic [1:0]       status
);

  ctlStrobe_t ctl;
  dpFlag_t    flags;
  portState_t state;

  psupDatapath #(
    .CUR_W(CUR_W), .TMR_W(TMR_W),
    .DEF_CUT(DEF_CUT), .DEF_MIN(DEF_MIN),
    .DEF_OVL_T(DEF_OVL_T), .DEF_UDL_T(DEF_UDL_T),
    .DEF_OVL_REC(DEF_OVL_REC), .DEF_UDL_REC(DEF_UDL_REC)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .tick1ms(tick1ms), .curCode(curCode),
    .cfgWe(cfgWe), .cfgCutThr(cfgCutThr), .cfgMinThr(cfgMinThr),
    .cfgOvlTime(cfgOvlTime), .cfgUdlTime(cfgUdlTime),
    .cfgOvlRec(cfgOvlRec), .cfgUdlRec(cfgUdlRec),
    .ctl(ctl), .flags(flags));

  psupControl control_i (
    .clk(clk), .rstN(rstN), .hostEn(hostEn), .killN(killN),
    .pwrGood(pwrGood), .flags(flags), .ctl(ctl), .state(state),
    .portOn(portOn));

  assign status = state;

endmodule

// File: tb/poePortSupervisor_tb_top.sv
module poePortSupervisor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CUR_W = 12;
  localparam int TMR_W = 16;
  localparam int VEC_W = 1+1+1+1+CUR_W+2+1+4;
  localparam int NVEC  = 42;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tick1ms = 1'b0;
  logic [CUR_W-1:0] curCode = '0;
  logic             hostEn = 1'b0, killN = 1'b1, pwrGood = 1'b1, cfgWe = 1'b0;
  logic [CUR_W-1:0] cfgCutThr = '0, cfgMinThr = '0;
  logic [TMR_W-1:0] cfgOvlTime = '0, cfgUdlTime = '0, cfgOvlRec = '0, cfgUdlRec = '0;
  logic             portOn;
  logic [1:0]       status;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  poePortSupervisor dut_i (
    .clk(clk), .rstN(rstN), .tick1ms(tick1ms), .curCode(curCode),
    .hostEn(hostEn), .killN(killN), .pwrGood(pwrGood), .cfgWe(cfgWe),
    .cfgCutThr(cfgCutThr), .cfgMinThr(cfgMinThr),
    .cfgOvlTime(cfgOvlTime), .cfgUdlTime(cfgUdlTime),
    .cfgOvlRec(cfgOvlRec), .cfgUdlRec(cfgUdlRec),
    .portOn(portOn), .status(status));

  // fields: hostEn killN pwrGood tick cur | expStatus expOn | req
  // config used: cut=100 min=10 ovlT=3 udlT=4 ovlRec=5 udlRec=2
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {4'b1110, 12'd50,  2'd1, 1'b1, 4'd2},   // R2 power up
    {4'b1111, 12'd150, 2'd1, 1'b1, 4'd5},   // R5 over 1
    {4'b1111, 12'd150, 2'd1, 1'b1, 4'd5},   // R5 over 2
    {4'b1111, 12'd50,  2'd1, 1'b1, 4'd5},   // R5 in range clears
    {4'b1111, 12'd150, 2'd1, 1'b1, 4'd5},   // R5 over 1
    {4'b1111, 12'd150, 2'd1, 1'b1, 4'd5},   // R5 over 2
    {4'b1110, 12'd150, 2'd1, 1'b1, 4'd12},  // R12 no tick
    {4'b1111, 12'd150, 2'd1, 1'b1, 4'd3},   // R3 over 3
    {4'b1111, 12'd150, 2'd2, 1'b0, 4'd3},   // R3 trip on 4th tick
    {4'b1111, 12'd50,  2'd2, 1'b0, 4'd6},   // R6 rec 1
    {4'b1111, 12'd50,  2'd2, 1'b0, 4'd6},   // R6 rec 2
    {4'b1110, 12'd50,  2'd2, 1'b0, 4'd12},  // R12 no tick
    {4'b1111, 12'd50,  2'd2, 1'b0, 4'd6},   // R6 rec 3
    {4'b1111, 12'd50,  2'd2, 1'b0, 4'd6},   // R6 rec 4
    {4'b1111, 12'd50,  2'd2, 1'b0, 4'd6},   // R6 rec 5
    {4'b1111, 12'd50,  2'd1, 1'b1, 4'd6},   // R6 retry on 6th tick
    {4'b1111, 12'd100, 2'd1, 1'b1, 4'd3},   // R3 equal not over
    {4'b1111, 12'd100, 2'd1, 1'b1, 4'd3},
    {4'b1111, 12'd100, 2'd1, 1'b1, 4'd3},
    {4'b1111, 12'd100, 2'd1, 1'b1, 4'd3},
    {4'b1111, 12'd100, 2'd1, 1'b1, 4'd3},
    {4'b1111, 12'd10,  2'd1, 1'b1, 4'd4},   // R4 equal not under
    {4'b1111, 12'd10,  2'd1, 1'b1, 4'd4},
    {4'b1111, 12'd10,  2'd1, 1'b1, 4'd4},
    {4'b1111, 12'd10,  2'd1, 1'b1, 4'd4},
    {4'b1111, 12'd10,  2'd1, 1'b1, 4'd4},
    {4'b1111, 12'd10,  2'd1, 1'b1, 4'd4},
    {4'b1111, 12'd0,   2'd1, 1'b1, 4'd4},   // R4 under 1
    {4'b1111, 12'd0,   2'd1, 1'b1, 4'd4},
    {4'b1111, 12'd0,   2'd1, 1'b1, 4'd4},
    {4'b1111, 12'd0,   2'd1, 1'b1, 4'd4},   // R4 under 4
    {4'b1111, 12'd0,   2'd3, 1'b0, 4'd4},   // R4 trip on 5th tick
    {4'b1111, 12'd50,  2'd3, 1'b0, 4'd7},   // R7 rec 1
    {4'b1111, 12'd50,  2'd3, 1'b0, 4'd7},   // R7 rec 2
    {4'b1111, 12'd50,  2'd1, 1'b1, 4'd7},   // R7 retry on 3rd tick
    {4'b1010, 12'd50,  2'd0, 1'b0, 4'd8},   // R8 kill
    {4'b1011, 12'd50,  2'd0, 1'b0, 4'd8},   // R8 stays off
    {4'b1110, 12'd50,  2'd1, 1'b1, 4'd8},   // R8 release
    {4'b1100, 12'd50,  2'd0, 1'b0, 4'd9},   // R9 supply fail
    {4'b1110, 12'd50,  2'd1, 1'b1, 4'd9},   // R9 supply back
    {4'b0110, 12'd50,  2'd0, 1'b0, 4'd10},  // R10 host off
    {4'b1110, 12'd50,  2'd1, 1'b1, 4'd10}   // R10 host on
  };

  task automatic check(input int req, input logic [1:0] expSt, input logic expOn);
    checks++;
    if (status !== expSt || portOn !== expOn) begin
      failures++;
      $display("FAIL R%0d status=%0d portOn=%0b expected status=%0d portOn=%0b",
               req, status, portOn, expSt, expOn);
    end
  endtask

  task automatic step(input logic h, input logic k, input logic p,
                      input logic t, input logic [CUR_W-1:0] c);
    @(negedge clk);
    hostEn = h; killN = k; pwrGood = p; tick1ms = t; curCode = c;
    @(posedge clk);
    #1;
  endtask

  task automatic writeCfg(input logic [TMR_W-1:0] ovlT);
    @(negedge clk);
    cfgWe = 1'b1; cfgCutThr = 12'd100; cfgMinThr = 12'd10;
    cfgOvlTime = ovlT; cfgUdlTime = 16'd4; cfgOvlRec = 16'd5; cfgUdlRec = 16'd2;
    tick1ms = 1'b0;
    @(posedge clk);
    #1;
    cfgWe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VEC_W-1:0] v;
    repeat (3) @(posedge clk);
    #1;
    check(1, 2'd0, 1'b0);          // R1 during reset
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check(1, 2'd0, 1'b0);          // R1 after reset, host disabled

    writeCfg(16'd3);

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      step(v[VEC_W-1], v[VEC_W-2], v[VEC_W-3], v[VEC_W-4], v[VEC_W-5 -: CUR_W]);
      check(int'(v[3:0]), v[6:5], v[4]);
    end

    // R8: portOn falls before any clock edge
    @(negedge clk); killN = 1'b0; tick1ms = 1'b0;
    #1;
    check(8, 2'd1, 1'b0);
    @(posedge clk); #1;
    check(8, 2'd0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 12'd50);
    check(8, 2'd1, 1'b1);

    // R9: supply failure removes power before the edge
    @(negedge clk); pwrGood = 1'b0;
    #1;
    check(9, 2'd1, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 12'd50);
    check(9, 2'd1, 1'b1);

    // R10: host-off during recovery discards the recovery count
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 12'd200);
    check(10, 2'd2, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'd50);
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'd50);
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'd50);
    check(10, 2'd0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 12'd50);
    check(10, 2'd1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 12'd200);
    check(10, 2'd2, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 12'd50);
    check(10, 2'd2, 1'b0);         // a kept count would have retried by now
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'd50);
    check(10, 2'd1, 1'b1);

    // R11: write while on is ignored; the old filter length still applies
    writeCfg(16'd0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'd200);
    check(11, 2'd1, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'd200);
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'd200);
    check(11, 2'd1, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'd200);
    check(11, 2'd2, 1'b0);

    // R11: write while off takes effect
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'd50);
    writeCfg(16'd0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 12'd50);
    check(11, 2'd1, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'd200);
    check(11, 2'd2, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule